// File: doc/BRIEF.md
# Cross-clock machine timer

This block keeps a 64-bit machine time value that advances on every edge of a free-running reference clock, which is asynchronous to the processor clock. It also keeps a 64-bit compare value, and it raises a level timer interrupt toward the processor whenever the time is equal to or beyond the compare value. The processor reaches both registers through a 32-bit register port with a 12-bit address, and each 64-bit register appears there as a lower and an upper half.

The register port is a request stream and a response stream, each with valid/ready. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. The block takes one request at a time. `req_ready` stays low from the accepting edge until the response has been taken. A response is presented on `rsp_valid` and is consumed on an edge where `rsp_ready` is also high. While `rsp_ready` is low, the response data and the illegal flag hold still.

Compare accesses complete in the processor domain. A time access crosses into the reference domain with a four-phase request/acknowledge exchange. For a write, the synchronized request acts as the write enable there. For a read, the reference domain freezes a 64-bit snapshot when it first sees the request and keeps it until the request drops. The upper and lower halves of one read therefore always come from the same count. The compare logic watches a Gray-coded copy of the time that is resynchronized into the processor domain.

Top module: `mtimer_xclk`

## Requirements
- R1: While `rst_n` is low, `rsp_valid`, `busy` and `timer_irq` are 0, and time and compare are cleared. The first reads after reset return a time that counts up from zero, with upper half 0, and a compare value of 0.
- R2: The time advances by exactly one on every reference clock edge unless a write lands on that edge. It cannot be stopped.
- R3: A write to 0xB01 replaces the lower 32 bits of time and a write to 0xB81 replaces the upper 32 bits. The other half keeps counting from its old value. The write response carries data 0 and no illegal flag.
- R4: Reads at 0xB01 and 0xC01 return the lower half of a time snapshot, and reads at 0xB81 and 0xC81 return the upper half. The snapshot is taken in the reference domain between acceptance and response, and carries from the lower half into the upper half are correct.
- R5: Compare lower and upper halves are read and written at 0xB21 and 0xBA1. Their response is valid in the cycle right after acceptance.
- R6: `timer_irq` is 1 when time ≥ compare and 0 when compare is above time. It follows within a few processor cycles, and it drops after compare is rewritten above the current time.
- R7: A request to any other address, or a write to 0xC01 or 0xC81, responds in the next cycle with data 0 and `rsp_illegal` 1, and changes neither time nor compare.
- R8: `busy` is 1 during the crossing of a time access. `req_ready` is 0 from acceptance until the response is consumed. A new crossing request is never raised while the previous acknowledge is still high.
- R9: While `rsp_valid` is 1 and `rsp_ready` is 0, `rsp_valid`, `rsp_data` and `rsp_illegal` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| ref_clk | input | 1 | Asynchronous reference clock that drives the time count |
| rst_n | input | 1 | Active-low asynchronous reset for both domains |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Register address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_data | output | 32 | Read data, 0 for writes and illegal accesses |
| rsp_illegal | output | 1 | Request named an unmapped or read-only address |
| busy | output | 1 | A time access is crossing clock domains |
| timer_irq | output | 1 | Time has reached the compare value |

## Verification
Compare and illegal accesses must show `rsp_valid` at the first sample after the accepting edge, and the bench measures that latency exactly. A time access takes a variable number of cycles, roughly two synchronizer passes in each direction, so the bench waits for `rsp_valid` and records the reference-edge count at acceptance and at response. It then requires the returned half to lie inside the window that the written base value and those two counts allow. The interrupt trails the count by a reference edge plus about four processor flops, so it is sampled twenty processor cycles after the stimulus, and only at moments where the modelled time is well clear of the compare value. Every clock, the bench also checks `req_ready` against its own record of whether a transaction is outstanding.

// File: rtl/mtimer_pkg.sv
package mtimer_pkg;

  localparam int unsigned HALF_W_DEF = 32;
  localparam int unsigned ADDR_W_DEF = 12;

  // register map; the decode depends on these exact values
  localparam logic [ADDR_W_DEF-1:0] ADR_TIME_LO  = 12'hB01;
  localparam logic [ADDR_W_DEF-1:0] ADR_TIME_HI  = 12'hB81;
  localparam logic [ADDR_W_DEF-1:0] ADR_CMP_LO   = 12'hB21;
  localparam logic [ADDR_W_DEF-1:0] ADR_CMP_HI   = 12'hBA1;
  localparam logic [ADDR_W_DEF-1:0] ADR_UTIME_LO = 12'hC01;
  localparam logic [ADDR_W_DEF-1:0] ADR_UTIME_HI = 12'hC81;

  typedef enum logic [1:0] {
    HS_IDLE,
    HS_WAIT_ACK,
    HS_WAIT_REL,
    HS_RESP
  } host_state_e;

  typedef enum logic [2:0] {
    OP_BAD,
    OP_TIME_RD,
    OP_TIME_WR,
    OP_CMP_RD,
    OP_CMP_WR
  } op_e;

  typedef struct packed {
    op_e  op;
    logic upper;
  } access_t;

  function automatic access_t decode_access(input logic [ADDR_W_DEF-1:0] addr,
                                            input logic wr);
    access_t a;
    a.op    = OP_BAD;
    a.upper = 1'b0;
    case (addr)
      ADR_TIME_LO:  a.op = wr ? OP_TIME_WR : OP_TIME_RD;
      ADR_TIME_HI:  begin a.op = wr ? OP_TIME_WR : OP_TIME_RD; a.upper = 1'b1; end
      ADR_CMP_LO:   a.op = wr ? OP_CMP_WR : OP_CMP_RD;
      ADR_CMP_HI:   begin a.op = wr ? OP_CMP_WR : OP_CMP_RD; a.upper = 1'b1; end
      ADR_UTIME_LO: a.op = wr ? OP_BAD : OP_TIME_RD;
      ADR_UTIME_HI: begin a.op = wr ? OP_BAD : OP_TIME_RD; a.upper = 1'b1; end
      default:      a.op = OP_BAD;
    endcase
    return a;
  endfunction

endpackage

// File: rtl/mt_sync.sv
module mt_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/mt_ref_core.sv
module mt_ref_core #(
  parameter int unsigned HALF_W      = 32,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned TIME_W     = 2 * HALF_W
) (
  input  logic              ref_clk,
  input  logic              rst_n,
  input  logic              wr_req_a,
  input  logic              wr_upper,
  input  logic [HALF_W-1:0] wr_half,
  input  logic              rd_req_a,
  output logic              wr_ack,
  output logic              rd_ack,
  output logic [TIME_W-1:0] snap,
  output logic [TIME_W-1:0] time_gray
);

  logic              wr_req_s, rd_req_s;
  logic              wr_ack_q, rd_ack_q;
  logic [TIME_W-1:0] time_q, time_next, snap_q, gray_q;
  logic              apply_wr, take_snap;

  mt_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_req_sync (
    .clk   (ref_clk),
    .rst_n (rst_n),
    .d     ({wr_req_a, rd_req_a}),
    .q     ({wr_req_s, rd_req_s})
  );

  // first cycle of a synchronized request: the crossing's enable
  assign apply_wr  = wr_req_s & ~wr_ack_q;
  assign take_snap = rd_req_s & ~rd_ack_q;

  always_comb begin
    if (apply_wr) begin
      if (wr_upper) time_next = {wr_half, time_q[HALF_W-1:0]};
      else          time_next = {time_q[TIME_W-1:HALF_W], wr_half};
    end else begin
      time_next = time_q + 1'b1;
    end
  end

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      time_q   <= '0;
      gray_q   <= '0;
      snap_q   <= '0;
      wr_ack_q <= 1'b0;
      rd_ack_q <= 1'b0;
    end else begin
      time_q   <= time_next;
      gray_q   <= time_next ^ (time_next >> 1);
      wr_ack_q <= wr_req_s;
      rd_ack_q <= rd_req_s;
      if (take_snap) snap_q <= time_q;
    end
  end

  assign wr_ack    = wr_ack_q;
  assign rd_ack    = rd_ack_q;
  assign snap      = snap_q;
  assign time_gray = gray_q;

  // R2
  time_step_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    !(wr_req_s && !wr_ack_q) |=> (time_q == $past(time_q) + 1'b1));

  // R3
  upper_write_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (wr_req_s && !wr_ack_q && wr_upper) |=> (time_q[TIME_W-1:HALF_W] == $past(wr_half)));

  // R4
  snap_hold_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (rd_ack_q && rd_req_s) |=> $stable(snap_q));

endmodule

// File: rtl/mt_irq_cmp.sv
module mt_irq_cmp #(
  parameter int unsigned TIME_W      = 64,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TIME_W-1:0] time_gray_a,
  input  logic [TIME_W-1:0] cmp,
  input  logic              freeze,
  output logic              irq
);

  logic [TIME_W-1:0] gray_s, time_bin, time_bin_q;
  logic              irq_q;

  mt_sync #(.WIDTH(TIME_W), .STAGES(SYNC_STAGES)) u_gray_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (time_gray_a),
    .q     (gray_s)
  );

  always_comb begin
    for (int i = 0; i < TIME_W; i++) begin
      time_bin[i] = ^(gray_s >> i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      time_bin_q <= '0;
      irq_q      <= 1'b0;
    end else begin
      time_bin_q <= time_bin;
      if (!freeze) irq_q <= (time_bin_q >= cmp);
    end
  end

  assign irq = irq_q;

  // R6
  irq_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    freeze |=> $stable(irq_q));

endmodule

// File: rtl/mt_host_ctrl.sv
module mt_host_ctrl
  import mtimer_pkg::*;
#(
  parameter int unsigned HALF_W  = HALF_W_DEF,
  parameter int unsigned ADDR_W  = ADDR_W_DEF,
  localparam int unsigned TIME_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [HALF_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [HALF_W-1:0] rsp_data,
  output logic              rsp_illegal,
  output logic              busy,
  output logic              wr_req,
  output logic              rd_req,
  output logic              wr_upper,
  output logic [HALF_W-1:0] wr_half,
  input  logic              wr_ack_s,
  input  logic              rd_ack_s,
  input  logic [TIME_W-1:0] snap,
  output logic [TIME_W-1:0] cmp,
  output logic              freeze
);

  host_state_e       state_q;
  access_t           dec;
  logic              accept, ack_s;
  logic              is_wr_q, upper_q, wr_req_q, rd_req_q, rsp_ill_q;
  logic [HALF_W-1:0] rsp_data_q, wr_half_q;
  logic [TIME_W-1:0] cmp_q;

  assign dec    = decode_access(req_addr, req_write);
  assign accept = req_valid && (state_q == HS_IDLE);
  assign ack_s  = is_wr_q ? wr_ack_s : rd_ack_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= HS_IDLE;
      is_wr_q    <= 1'b0;
      upper_q    <= 1'b0;
      wr_req_q   <= 1'b0;
      rd_req_q   <= 1'b0;
      rsp_ill_q  <= 1'b0;
      rsp_data_q <= '0;
      wr_half_q  <= '0;
      cmp_q      <= '0;
    end else begin
      case (state_q)
        HS_IDLE: begin
          if (accept) begin
            upper_q    <= dec.upper;
            rsp_ill_q  <= 1'b0;
            rsp_data_q <= '0;
            case (dec.op)
              OP_TIME_RD: begin
                rd_req_q <= 1'b1;
                is_wr_q  <= 1'b0;
                state_q  <= HS_WAIT_ACK;
              end
              OP_TIME_WR: begin
                wr_req_q  <= 1'b1;
                is_wr_q   <= 1'b1;
                wr_half_q <= req_wdata;
                state_q   <= HS_WAIT_ACK;
              end
              OP_CMP_RD: begin
                rsp_data_q <= dec.upper ? cmp_q[TIME_W-1:HALF_W] : cmp_q[HALF_W-1:0];
                state_q    <= HS_RESP;
              end
              OP_CMP_WR: begin
                if (dec.upper) cmp_q[TIME_W-1:HALF_W] <= req_wdata;
                else           cmp_q[HALF_W-1:0]      <= req_wdata;
                state_q <= HS_RESP;
              end
              default: begin
                rsp_ill_q <= 1'b1;
                state_q   <= HS_RESP;
              end
            endcase
          end
        end
        HS_WAIT_ACK: begin
          if (ack_s) begin
            if (!is_wr_q)
              rsp_data_q <= upper_q ? snap[TIME_W-1:HALF_W] : snap[HALF_W-1:0];
            wr_req_q <= 1'b0;
            rd_req_q <= 1'b0;
            state_q  <= HS_WAIT_REL;
          end
        end
        HS_WAIT_REL: begin
          if (!ack_s) state_q <= HS_RESP;
        end
        default: begin
          if (rsp_ready) state_q <= HS_IDLE;
        end
      endcase
    end
  end

  assign req_ready   = (state_q == HS_IDLE);
  assign rsp_valid   = (state_q == HS_RESP);
  assign rsp_data    = rsp_data_q;
  assign rsp_illegal = rsp_ill_q;
  assign busy        = (state_q == HS_WAIT_ACK) || (state_q == HS_WAIT_REL);
  assign wr_req      = wr_req_q;
  assign rd_req      = rd_req_q;
  assign wr_upper    = upper_q;
  assign wr_half     = wr_half_q;
  assign cmp         = cmp_q;
  assign freeze      = busy && is_wr_q;

  // R9
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data) && $stable(rsp_illegal)));

  // R7
  illegal_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_illegal) |-> (rsp_data == '0));

  // R8
  rd_four_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_req_q) |-> !rd_ack_s);

  // R8
  wr_four_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_req_q) |-> !wr_ack_s);

  // R8
  one_crossing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_req_q, rd_req_q}));

  // R8
  release_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_req_q) |-> $past(rd_ack_s));

endmodule

// File: rtl/mtimer_xclk.sv
module mtimer_xclk
  import mtimer_pkg::*;
#(
  parameter int unsigned HALF_W      = HALF_W_DEF,
  parameter int unsigned ADDR_W      = ADDR_W_DEF,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned TIME_W     = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              ref_clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [HALF_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [HALF_W-1:0] rsp_data,
  output logic              rsp_illegal,
  output logic              busy,
  output logic              timer_irq
);

  logic              wr_req, rd_req, wr_upper, freeze;
  logic              wr_ack, rd_ack, wr_ack_s, rd_ack_s;
  logic [HALF_W-1:0] wr_half;
  logic [TIME_W-1:0] snap, time_gray, cmp;

  mt_host_ctrl #(.HALF_W(HALF_W), .ADDR_W(ADDR_W)) u_host (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_write   (req_write),
    .req_addr    (req_addr),
    .req_wdata   (req_wdata),
    .rsp_valid   (rsp_valid),
    .rsp_ready   (rsp_ready),
    .rsp_data    (rsp_data),
    .rsp_illegal (rsp_illegal),
    .busy        (busy),
    .wr_req      (wr_req),
    .rd_req      (rd_req),
    .wr_upper    (wr_upper),
    .wr_half     (wr_half),
    .wr_ack_s    (wr_ack_s),
    .rd_ack_s    (rd_ack_s),
    .snap        (snap),
    .cmp         (cmp),
    .freeze      (freeze)
  );

  mt_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_ack_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({wr_ack, rd_ack}),
    .q     ({wr_ack_s, rd_ack_s})
  );

  mt_ref_core #(.HALF_W(HALF_W), .SYNC_STAGES(SYNC_STAGES)) u_ref (
    .ref_clk   (ref_clk),
    .rst_n     (rst_n),
    .wr_req_a  (wr_req),
    .wr_upper  (wr_upper),
    .wr_half   (wr_half),
    .rd_req_a  (rd_req),
    .wr_ack    (wr_ack),
    .rd_ack    (rd_ack),
    .snap      (snap),
    .time_gray (time_gray)
  );

  mt_irq_cmp #(.TIME_W(TIME_W), .SYNC_STAGES(SYNC_STAGES)) u_irq (
    .clk         (clk),
    .rst_n       (rst_n),
    .time_gray_a (time_gray),
    .cmp         (cmp),
    .freeze      (freeze),
    .irq         (timer_irq)
  );

endmodule

// File: tb/mtimer_xclk_test.sv
`timescale 1ns/1ps
module mtimer_xclk_test;

  logic        clk = 1'b0, ref_clk = 1'b0, rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b1;
  logic [11:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        req_ready, rsp_valid, rsp_illegal, busy, timer_irq;
  logic [31:0] rsp_data;

  int checks = 0;
  int fails  = 0;
  bit pending = 1'b0;

  // behavioural time model: value = base + (edges since the write landed)
  logic [63:0] ref_edges = '0;
  logic [63:0] base = '0;
  logic [63:0] w_lo = '0;
  logic [63:0] w_hi = '0;
  logic [63:0] cmp_model = '0;

  mtimer_xclk uut (
    .clk(clk), .ref_clk(ref_clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .rsp_illegal(rsp_illegal), .busy(busy), .timer_irq(timer_irq)
  );

  always #2 clk = ~clk;
  always #6.5 ref_clk = ~ref_clk;

  always @(posedge ref_clk) if (rst_n) ref_edges <= ref_edges + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // R8: every clock, ready must mirror the bench's outstanding record
  always @(negedge clk) begin
    if (rst_n) begin
      check((req_ready == !pending) && (!rsp_valid || pending), "R8",
            "req_ready vs outstanding", {62'd0, req_ready, rsp_valid}, {63'd0, !pending});
    end
  end

  function automatic logic [63:0] tmin(input logic [63:0] e);
    return base + e - w_hi - ((base + e - w_hi) != 0 ? 64'd1 : 64'd0);
  endfunction
  function automatic logic [63:0] tmax(input logic [63:0] e);
    return base + e - w_lo + 64'd1;
  endfunction

  task automatic xact(input bit wr, input logic [11:0] addr, input logic [31:0] wd,
                      input int hold, output logic [31:0] rd, output bit ill,
                      output logic [63:0] e0, output logic [63:0] e1,
                      output int lat, output bit saw_busy);
    int waitc = 0;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = addr; req_wdata = wd;
    while (!req_ready && waitc < 500) begin @(negedge clk); waitc++; end
    e0 = ref_edges;
    @(posedge clk);
    pending = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1; saw_busy = 1'b0;
    while (!rsp_valid && lat < 1000) begin
      if (busy) saw_busy = 1'b1;
      @(negedge clk);
      lat++;
    end
    if (lat >= 1000) check(1'b0, "R8", "response timeout", 64'd0, 64'd1);
    rd = rsp_data; ill = rsp_illegal; e1 = ref_edges;
    if (hold > 0) begin
      rsp_ready = 1'b0;
      for (int k = 0; k < hold; k++) begin
        @(negedge clk);
        check(rsp_valid && rsp_data == rd && rsp_illegal == ill, "R9",
              "response held under back-pressure", {31'd0, rsp_valid, rsp_data}, {31'd1, rd});
      end
      rsp_ready = 1'b1;
    end
    @(posedge clk);
    pending = 1'b0;
  endtask

  task automatic check_half(input bit upper, input logic [31:0] v, input logic [63:0] e0,
                            input logic [63:0] e1, input string req);
    logic [63:0] mn, mx;
    bit ok;
    mn = tmin(e0);
    mx = tmax(e1);
    if (upper) ok = (v == mn[63:32]) || (v == mx[63:32]);
    else if (mn[63:32] == mx[63:32]) ok = (v >= mn[31:0]) && (v <= mx[31:0]);
    else ok = (v >= mn[31:0]) || (v <= mx[31:0]);
    check(ok, req, $sformatf("time half (upper=%0d) in window up to %h", upper, mx),
          {32'd0, v}, upper ? {32'd0, mn[63:32]} : {32'd0, mn[31:0]});
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] d, d2;
    bit ill, sb;
    logic [63:0] e0, e1, f0, f1, now;
    int lat;

    // R1: reset state
    repeat (10) @(negedge clk);
    check(!rsp_valid && !busy && !timer_irq, "R1", "outputs idle in reset",
          {61'd0, rsp_valid, busy, timer_irq}, 64'd0);
    rst_n = 1'b1;
    settle(5);

    // R1 R2: time counts from zero after reset
    xact(0, 12'hB01, 0, 0, d, ill, e0, e1, lat, sb);
    check_half(0, d, e0, e1, "R1");
    check(!ill, "R1", "time read legal", {63'd0, ill}, 64'd0);
    check(sb, "R8", "busy seen during time read", {63'd0, sb}, 64'd1);
    xact(0, 12'hB81, 0, 0, d, ill, e0, e1, lat, sb);
    check(d == 0, "R1", "upper time zero", {32'd0, d}, 64'd0);
    xact(0, 12'hB21, 0, 0, d, ill, e0, e1, lat, sb);
    check(d == 0, "R1", "compare zero after reset", {32'd0, d}, 64'd0);
    check(lat == 1, "R5", "compare read latency", lat, 64'd1);

    // R6: time >= compare(0)
    settle(20);
    check(timer_irq == 1'b1, "R6", "irq with compare zero", {63'd0, timer_irq}, 64'd1);

    // R4 R2: user view and monotonic
    xact(0, 12'hC01, 0, 0, d, ill, e0, e1, lat, sb);
    check_half(0, d, e0, e1, "R4");
    settle(30);
    xact(0, 12'hC01, 0, 0, d2, ill, f0, f1, lat, sb);
    check_half(0, d2, f0, f1, "R2");
    check(d2 > d, "R2", "time advanced between reads", {32'd0, d2}, {32'd0, d});

    // R3: upper write keeps lower counting
    xact(1, 12'hB81, 32'h0000_0005, 0, d, ill, e0, e1, lat, sb);
    check(d == 0 && !ill, "R3", "write response", {31'd0, ill, d}, 64'd0);
    base = {32'h0000_0005, base[31:0]};
    xact(0, 12'hB81, 0, 0, d, ill, e0, e1, lat, sb);
    check(d == 32'h5, "R3", "upper half written", {32'd0, d}, 64'h5);
    xact(0, 12'hB01, 0, 0, d, ill, e0, e1, lat, sb);
    check_half(0, d, e0, e1, "R3");

    // R3 R4: lower write near carry
    xact(1, 12'hB01, 32'hFFFF_FF00, 0, d, ill, e0, e1, lat, sb);
    base = {32'h0000_0005, 32'hFFFF_FF00}; w_lo = e0; w_hi = e1;
    xact(0, 12'hC81, 0, 0, d, ill, e0, e1, lat, sb);
    check(d == 32'h5, "R3", "upper unchanged by lower write", {32'd0, d}, 64'h5);
    xact(0, 12'hB01, 0, 0, d, ill, e0, e1, lat, sb);
    check_half(0, d, e0, e1, "R3");
    settle(1200);
    xact(0, 12'hB81, 0, 0, d, ill, e0, e1, lat, sb);
    check(d == 32'h6, "R4", "carry into upper half", {32'd0, d}, 64'h6);
    xact(0, 12'hC01, 0, 0, d, ill, e0, e1, lat, sb);
    check_half(0, d, e0, e1, "R4");

    // R7: illegal accesses
    xact(1, 12'hC01, 32'h0000_1234, 0, d, ill, e0, e1, lat, sb);
    check(ill && d == 0, "R7", "write to read-only view", {31'd0, ill, d}, {31'd0, 1'b1, 32'd0});
    check(lat == 1, "R7", "illegal latency", lat, 64'd1);
    xact(0, 12'hB01, 0, 0, d, ill, e0, e1, lat, sb);
    check_half(0, d, e0, e1, "R7");
    xact(0, 12'hB02, 0, 0, d, ill, e0, e1, lat, sb);
    check(ill && d == 0, "R7", "unmapped read", {31'd0, ill, d}, {31'd0, 1'b1, 32'd0});
    xact(1, 12'h7FF, 32'hFFFF_FFFF, 0, d, ill, e0, e1, lat, sb);
    check(ill && d == 0, "R7", "unmapped write", {31'd0, ill, d}, {31'd0, 1'b1, 32'd0});
    xact(0, 12'hB21, 0, 0, d, ill, e0, e1, lat, sb);
    check(d == 0 && !ill, "R7", "compare untouched", {31'd0, ill, d}, 64'd0);

    // R5 R6: compare above time
    xact(1, 12'hBA1, 32'h7, 0, d, ill, e0, e1, lat, sb);
    check(lat == 1 && !ill, "R5", "compare write latency", lat, 64'd1);
    cmp_model = {32'h7, 32'h0};
    settle(20);
    check(timer_irq == 1'b0, "R6", "irq clears with compare above time", {63'd0, timer_irq}, 64'd0);
    xact(0, 12'hBA1, 0, 0, d, ill, e0, e1, lat, sb);
    check(d == 32'h7, "R5", "compare upper readback", {32'd0, d}, 64'h7);

    // R6: compare reached while waiting
    now = tmax(ref_edges);
    xact(1, 12'hB21, now[31:0] + 32'd500, 0, d, ill, e0, e1, lat, sb);
    xact(1, 12'hBA1, now[63:32], 0, d, ill, e0, e1, lat, sb);
    cmp_model = {now[63:32], now[31:0] + 32'd500};
    xact(0, 12'hB21, 0, 0, d, ill, e0, e1, lat, sb);
    check(d == cmp_model[31:0], "R5", "compare lower readback", {32'd0, d}, {32'd0, cmp_model[31:0]});
    settle(20);
    check(tmax(ref_edges) + 10 < cmp_model && timer_irq == 1'b0, "R6", "irq low before match",
          {63'd0, timer_irq}, 64'd0);
    while (tmin(ref_edges) < cmp_model + 5) @(negedge clk);
    settle(20);
    check(timer_irq == 1'b1, "R6", "irq after time passes compare", {63'd0, timer_irq}, 64'd1);
    xact(1, 12'hB21, 32'hFFFF_0000, 0, d, ill, e0, e1, lat, sb);
    settle(20);
    check(timer_irq == 1'b0, "R6", "irq drops on compare rewrite", {63'd0, timer_irq}, 64'd0);

    // R9: back-pressure on both response kinds
    xact(0, 12'hB21, 0, 5, d, ill, e0, e1, lat, sb);
    check(d == 32'hFFFF_0000, "R9", "held compare data", {32'd0, d}, 64'hFFFF_0000);
    xact(0, 12'hB01, 0, 3, d, ill, e0, e1, lat, sb);
    check_half(0, d, e0, e1, "R9");

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule